// File: doc/BRIEF.md
# Sector Program Gate and Write-Cycle Timer

This block sits behind a serial-memory front end and decides whether a write command may reach storage. The front end reports each frame through single-cycle strobes: chip select falling, the opcode, the captured byte address, each data byte, and chip select rising together with the number of serial clocks seen in the frame. The block holds the write-enable latch, a 3-bit lock code that shields part of the array, and a buffer that collects one sector of data.

A write is accepted only when the enable latch is set, the protect pin stayed high for the whole frame, no write cycle is running, and the frame ended on the exact clock count that the command requires. An accepted write starts a self-timed busy period counted in system clocks. In the last busy cycle the block presents the whole buffered sector on a wide write port, or loads the new lock code. Storage is outside the block.

Top module: `pgc_top`

## Requirements
- R1: After reset the enable latch, busy, the lock code and the memory write strobe are all 0. Opcode 0x06 sets the enable latch and 0x04 clears it, but only when chip select rises with a clock count of exactly 8. Any other count leaves the latch unchanged.
- R2: A sector program (opcode 0x02) starts only when the latch is set, the start address has its low 4 bits at zero, and chip select rises with a clock count of exactly 152, which is 8 opcode, 16 address and 128 data clocks. Any other count, or a misaligned start, starts nothing.
- R3: The lock code protects these sector ranges of the 512-byte array: 0 none, 1 0x000-0x07F, 2 0x080-0x0FF, 3 0x100-0x17F, 4 0x180-0x1FF, 5 0x000-0x0FF, 6 0x000-0x00F, 7 0x1F0-0x1FF. A program aimed at a protected sector starts no cycle and leaves the latch set.
- R4: If the protect pin is low at any point between chip select falling and rising, including the rising cycle, no write starts. A low pin during a running cycle does not stop it.
- R5: An accepted write raises busy in the cycle after chip select rises and holds it for exactly WRITE_CYCLES cycles. For a program, the write strobe is high for one cycle, the last busy cycle. In that cycle the sector output holds address bits [8:4], and the data line carries data byte k in bits [8k+7:8k].
- R6: When a sector program completes, the enable latch is cleared.
- R7: A status write (opcode 0x01) starts when the latch is set and chip select rises with a count of at least 16 that is a multiple of 8. The lock code becomes bits [2:0] of the last data byte at the end of the cycle. A partial byte starts nothing, and the latch stays set afterwards.
- R8: While busy, every command is ignored: loads into the buffer, status bytes, changes to the enable latch and new writes. This also holds for a frame that overlaps a busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Pulse: chip select fell |
| csRise | input | 1 | Pulse: chip select rose |
| sckCount | input | CNT_W | Serial clocks in the frame, valid with csRise |
| opValid | input | 1 | Pulse: opcode byte received |
| opCode | input | 8 | Opcode value |
| addrValid | input | 1 | Pulse: address received |
| addrIn | input | ADDR_W | Byte address |
| dataValid | input | 1 | Pulse: data byte received |
| dataIn | input | 8 | Data byte |
| protectN | input | 1 | Program-protect pin, low blocks writes |
| busy | output | 1 | Write cycle running |
| progEnable | output | 1 | Enable latch state |
| lockCode | output | 3 | Current lock code |
| memWe | output | 1 | Sector write strobe |
| memSector | output | ADDR_W-4 | Sector being written |
| memLine | output | 8*SECTOR_BYTES | Sector data, byte 0 lowest |

## Verification
Assertions check several properties on every cycle. Busy can rise only in the cycle after chip select rises, with the latch set and the pin high. A completed program always leaves the latch clear. The lock code never moves outside a status commit. Nothing loads while busy. Only the bench scenarios can show the rest: the exact clock-count rule, the eight lock ranges swept across every sector, the busy length, the byte order on the write line, and that a frame overlapping busy is dropped.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam logic [7:0] OP_SET_EN = 8'h06;
  localparam logic [7:0] OP_CLR_EN = 8'h04;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_WSTAT  = 8'h01;

  typedef enum logic [1:0] {KIND_NONE, KIND_PROG, KIND_STAT} wrKind_t;

  typedef struct packed {
    logic latchAddr;
    logic loadByte;
    logic loadStat;
    logic commitProg;
    logic commitStat;
  } ctrlStrobe_t;
endpackage

// File: rtl/pgc_ctrl.sv
module pgc_ctrl import pgc_pkg::*; #(
  parameter int ADDR_W       = 9,
  parameter int SECTOR_BYTES = 16,
  parameter int WRITE_CYCLES = 50,
  parameter int CNT_W        = 12,
  localparam int OFF_W       = $clog2(SECTOR_BYTES),
  localparam int SECT_W      = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              csRise,
  input  logic [CNT_W-1:0]  sckCount,
  input  logic              opValid,
  input  logic [7:0]        opCode,
  input  logic              addrValid,
  input  logic              dataValid,
  input  logic              protectN,
  input  logic [SECT_W-1:0] sectorIdx,
  input  logic [OFF_W-1:0]  sectorOff,
  input  logic [2:0]        lockCode,
  output logic              busy,
  output logic              progEnable,
  output ctrlStrobe_t       st
);
  localparam int NSECT = 1 << SECT_W;
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [SECT_W:0] Q1 = (SECT_W+1)'(NSECT / 4);
  localparam logic [SECT_W:0] Q2 = (SECT_W+1)'(NSECT / 2);
  localparam logic [SECT_W:0] Q3 = (SECT_W+1)'(3 * NSECT / 4);
  localparam logic [SECT_W:0] LASTS = (SECT_W+1)'(NSECT - 1);
  localparam logic [CNT_W-1:0] BITS_CMD   = CNT_W'(8);
  localparam logic [CNT_W-1:0] BITS_STAT  = CNT_W'(16);
  localparam logic [CNT_W-1:0] BITS_FRAME = CNT_W'(24 + 8 * SECTOR_BYTES);

  logic [7:0]       opReg;
  logic             sawBusy, sawLow;
  logic [TMR_W-1:0] tmr;
  wrKind_t          kind;
  logic             sectProt;
  logic [SECT_W:0]  sx;
  logic             okBusy, okProt, startProg, startStat, cmdEdge;

  assign sx = {1'b0, sectorIdx};

  always_comb begin
    unique case (lockCode)
      3'd1:    sectProt = sx < Q1;
      3'd2:    sectProt = (sx >= Q1) && (sx < Q2);
      3'd3:    sectProt = (sx >= Q2) && (sx < Q3);
      3'd4:    sectProt = sx >= Q3;
      3'd5:    sectProt = sx < Q2;
      3'd6:    sectProt = sx == '0;
      3'd7:    sectProt = sx == LASTS;
      default: sectProt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg <= '0; sawBusy <= 1'b0; sawLow <= 1'b0;
    end else if (frameStart) begin
      opReg <= '0; sawBusy <= busy; sawLow <= !protectN;
    end else begin
      if (opValid) opReg <= opCode;
      if (busy) sawBusy <= 1'b1;
      if (!protectN) sawLow <= 1'b1;
    end
  end

  assign okBusy    = !busy && !sawBusy;
  assign okProt    = protectN && !sawLow;
  assign cmdEdge   = csRise && okBusy && (sckCount == BITS_CMD);
  assign startProg = csRise && okBusy && okProt && progEnable && (opReg == OP_PROG)
                     && (sckCount == BITS_FRAME) && (sectorOff == '0) && !sectProt;
  assign startStat = csRise && okBusy && okProt && progEnable && (opReg == OP_WSTAT)
                     && (sckCount >= BITS_STAT) && (sckCount[2:0] == 3'd0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; tmr <= '0; kind <= KIND_NONE;
    end else if (busy) begin
      if (tmr == '0) begin
        busy <= 1'b0; kind <= KIND_NONE;
      end else begin
        tmr <= tmr - 1'b1;
      end
    end else if (startProg || startStat) begin
      busy <= 1'b1;
      tmr  <= TMR_W'(WRITE_CYCLES - 1);
      kind <= startProg ? KIND_PROG : KIND_STAT;
    end
  end

  always_comb begin
    st.latchAddr  = addrValid && !busy;
    st.loadByte   = dataValid && !busy && !sawBusy && (opReg == OP_PROG);
    st.loadStat   = dataValid && !busy && !sawBusy && (opReg == OP_WSTAT);
    st.commitProg = busy && (tmr == '0) && (kind == KIND_PROG);
    st.commitStat = busy && (tmr == '0) && (kind == KIND_STAT);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                    progEnable <= 1'b0;
    else if (st.commitProg)                       progEnable <= 1'b0;
    else if (cmdEdge && (opReg == OP_SET_EN))     progEnable <= 1'b1;
    else if (cmdEdge && (opReg == OP_CLR_EN))     progEnable <= 1'b0;
  end

  // R2: a cycle only begins from an enabled latch
  p_start_needs_enable_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(progEnable));
  // R5: a cycle begins right after chip select rises
  p_start_on_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise));
  // R4: a low protect pin at the rising edge blocks the start
  p_pin_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(protectN));
  // R6: a finished program leaves the latch clear
  p_enable_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.commitProg |=> !progEnable);
  // R8: no data is taken in while a cycle runs
  p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(st.loadByte || st.loadStat));
endmodule

// File: rtl/pgc_data.sv
module pgc_data import pgc_pkg::*; #(
  parameter int ADDR_W       = 9,
  parameter int SECTOR_BYTES = 16,
  localparam int OFF_W       = $clog2(SECTOR_BYTES),
  localparam int SECT_W      = ADDR_W - OFF_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               st,
  input  logic [ADDR_W-1:0]         addrIn,
  input  logic [7:0]                dataIn,
  output logic [SECT_W-1:0]         sectorIdx,
  output logic [OFF_W-1:0]          sectorOff,
  output logic [2:0]                lockCode,
  output logic                      memWe,
  output logic [SECT_W-1:0]         memSector,
  output logic [8*SECTOR_BYTES-1:0] memLine
);
  localparam logic [OFF_W:0] FULL = (OFF_W+1)'(SECTOR_BYTES);

  logic [ADDR_W-1:0] addrReg;
  logic [OFF_W:0]    byteIdx;
  logic [2:0]        statNext;
  logic [7:0]        secBuf [SECTOR_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0; byteIdx <= '0; statNext <= '0; lockCode <= '0;
    end else begin
      if (st.latchAddr) begin
        addrReg <= addrIn;
        byteIdx <= '0;
      end else if (st.loadByte && (byteIdx < FULL)) begin
        byteIdx <= byteIdx + 1'b1;
      end
      if (st.loadStat)   statNext <= dataIn[2:0];
      if (st.commitStat) lockCode <= statNext;
    end
  end

  always_ff @(posedge clk) begin
    if (st.loadByte && !st.latchAddr && (byteIdx < FULL))
      secBuf[byteIdx[OFF_W-1:0]] <= dataIn;
  end

  assign sectorIdx = addrReg[ADDR_W-1:OFF_W];
  assign sectorOff = addrReg[OFF_W-1:0];
  assign memWe     = st.commitProg;
  assign memSector = sectorIdx;

  for (genvar i = 0; i < SECTOR_BYTES; i++) begin : g_line
    assign memLine[8*i +: 8] = secBuf[i];
  end

  // R7: the lock code only moves on a status commit
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !st.commitStat |=> $stable(lockCode));
endmodule

// File: rtl/pgc_top.sv
module pgc_top import pgc_pkg::*; #(
  parameter int ADDR_W       = 9,
  parameter int SECTOR_BYTES = 16,
  parameter int WRITE_CYCLES = 50,
  parameter int CNT_W        = 12,
  localparam int OFF_W       = $clog2(SECTOR_BYTES),
  localparam int SECT_W      = ADDR_W - OFF_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frameStart,
  input  logic                      csRise,
  input  logic [CNT_W-1:0]          sckCount,
  input  logic                      opValid,
  input  logic [7:0]                opCode,
  input  logic                      addrValid,
  input  logic [ADDR_W-1:0]         addrIn,
  input  logic                      dataValid,
  input  logic [7:0]                dataIn,
  input  logic                      protectN,
  output logic                      busy,
  output logic                      progEnable,
  output logic [2:0]                lockCode,
  output logic                      memWe,
  output logic [SECT_W-1:0]         memSector,
  output logic [8*SECTOR_BYTES-1:0] memLine
);
  ctrlStrobe_t       st;
  logic [SECT_W-1:0] sectorIdx;
  logic [OFF_W-1:0]  sectorOff;

  pgc_ctrl #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES),
             .WRITE_CYCLES(WRITE_CYCLES), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .csRise(csRise),
    .sckCount(sckCount), .opValid(opValid), .opCode(opCode),
    .addrValid(addrValid), .dataValid(dataValid), .protectN(protectN),
    .sectorIdx(sectorIdx), .sectorOff(sectorOff), .lockCode(lockCode),
    .busy(busy), .progEnable(progEnable), .st(st));

  pgc_data #(.ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .addrIn(addrIn), .dataIn(dataIn),
    .sectorIdx(sectorIdx), .sectorOff(sectorOff), .lockCode(lockCode),
    .memWe(memWe), .memSector(memSector), .memLine(memLine));
endmodule

// File: tb/sim_pgc_top.sv
module sim_pgc_top;
  localparam int WC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStart = 0, csRise = 0, opValid = 0, addrValid = 0, dataValid = 0;
  logic protectN = 1'b1;
  logic [11:0] sckCount = '0;
  logic [7:0] opCode = '0, dataIn = '0;
  logic [8:0] addrIn = '0;
  logic busy, progEnable, memWe;
  logic [2:0] lockCode;
  logic [4:0] memSector;
  logic [127:0] memLine;

  int tests = 0, fails = 0;
  int busyCnt, weCnt, gotSect;
  logic [127:0] gotLine;

  always #2 clk = ~clk;

  pgc_top #(.WRITE_CYCLES(WC)) u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .csRise(csRise),
    .sckCount(sckCount), .opValid(opValid), .opCode(opCode),
    .addrValid(addrValid), .addrIn(addrIn), .dataValid(dataValid),
    .dataIn(dataIn), .protectN(protectN), .busy(busy),
    .progEnable(progEnable), .lockCode(lockCode), .memWe(memWe),
    .memSector(memSector), .memLine(memLine));

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkLine(string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic startFrame;
    frameStart = 1; tick; frameStart = 0; tick;
  endtask
  task automatic sendOp(logic [7:0] op);
    opValid = 1; opCode = op; tick; opValid = 0; tick;
  endtask
  task automatic sendAddr(logic [8:0] a);
    addrValid = 1; addrIn = a; tick; addrValid = 0; tick;
  endtask
  task automatic sendData(logic [7:0] d);
    dataValid = 1; dataIn = d; tick; dataValid = 0; tick;
  endtask
  task automatic endFrame(int cnt);
    sckCount = 12'(cnt); csRise = 1; tick; csRise = 0;
  endtask

  task automatic watch;
    busyCnt = 0; weCnt = 0; gotSect = -1; gotLine = '0;
    for (int i = 0; i < WC + 4; i++) begin
      if (busy) busyCnt++;
      if (memWe) begin weCnt++; gotSect = int'(memSector); gotLine = memLine; end
      tick;
    end
  endtask

  function automatic logic [7:0] pat(int seed, int k);
    return 8'(seed * 7 + k * 13 + 5);
  endfunction

  function automatic logic [127:0] patLine(int seed);
    logic [127:0] l;
    for (int k = 0; k < 16; k++) l[8*k +: 8] = pat(seed, k);
    return l;
  endfunction

  function automatic bit isProt(int code, int sect);
    int a, lo, hi;
    a = sect * 16;
    case (code)
      1: begin lo = 0;   hi = 127; end
      2: begin lo = 128; hi = 255; end
      3: begin lo = 256; hi = 383; end
      4: begin lo = 384; hi = 511; end
      5: begin lo = 0;   hi = 255; end
      6: begin lo = 0;   hi = 15;  end
      7: begin lo = 496; hi = 511; end
      default: begin lo = 1; hi = 0; end
    endcase
    return (a >= lo) && (a <= hi);
  endfunction

  task automatic cmd(logic [7:0] op, int cnt);
    startFrame; sendOp(op); endFrame(cnt); tick;
  endtask

  task automatic progFrame(int a, int nBytes, int seed, int cnt);
    startFrame; sendOp(8'h02); sendAddr(9'(a));
    for (int k = 0; k < nBytes; k++) sendData(pat(seed, k));
    endFrame(cnt);
  endtask

  task automatic setLock(int code);
    cmd(8'h06, 8);
    startFrame; sendOp(8'h01); sendData(8'(code)); endFrame(16); watch;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick;
    rstN = 1; tick;
    // R1 reset state
    chk("R1 reset enable", int'(progEnable), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset lock", int'(lockCode), 0);
    chk("R5 reset we", int'(memWe), 0);

    // R2 program with latch clear
    progFrame(32, 16, 1, 152); watch;
    chk("R2 no enable busy", busyCnt, 0);

    // R1 enable frame with extra clocks is ignored
    cmd(8'h06, 16);
    chk("R1 extra clocks", int'(progEnable), 0);
    cmd(8'h06, 8);
    chk("R1 set", int'(progEnable), 1);
    cmd(8'h04, 8);
    chk("R1 clear", int'(progEnable), 0);

    // R7 status write and busy length
    setLock(5);
    chk("R7 lock loaded", int'(lockCode), 5);
    chk("R5 status busy len", busyCnt, WC);
    chk("R7 enable kept", int'(progEnable), 1);
    startFrame; sendOp(8'h01); sendData(8'h03); sendData(8'hF2); endFrame(24); watch;
    chk("R7 last byte wins", int'(lockCode), 2);
    startFrame; sendOp(8'h01); sendData(8'h04); endFrame(20); watch;
    chk("R7 partial byte busy", busyCnt, 0);
    chk("R7 partial byte lock", int'(lockCode), 2);

    // R3 sweep over every lock code and sector
    for (int code = 0; code < 8; code++) begin
      setLock(code);
      chk("R7 sweep lock", int'(lockCode), code);
      for (int s = 0; s < 32; s++) begin
        bit p;
        p = isProt(code, s);
        cmd(8'h06, 8);
        progFrame(s * 16, 16, s + code * 32, 152); watch;
        chk("R3 write happens", weCnt, p ? 0 : 1);
        chk("R6 R3 latch after", int'(progEnable), p ? 1 : 0);
        if (!p) begin
          chk("R5 busy len", busyCnt, WC);
          chk("R5 sector", gotSect, s);
          chkLine("R5 line", gotLine, patLine(s + code * 32));
        end
      end
    end
    setLock(0);

    // R2 count and alignment rules
    cmd(8'h06, 8);
    progFrame(64, 16, 3, 151); watch; chk("R2 count 151", busyCnt, 0);
    progFrame(64, 16, 3, 160); watch; chk("R2 count 160", busyCnt, 0);
    progFrame(64, 15, 3, 144); watch; chk("R2 fifteen bytes", busyCnt, 0);
    progFrame(67, 16, 3, 152); watch; chk("R2 misaligned", busyCnt, 0);
    chk("R2 latch kept", int'(progEnable), 1);

    // R4 protect pin
    startFrame; sendOp(8'h02); protectN = 0; sendAddr(9'd80); protectN = 1;
    for (int k = 0; k < 16; k++) sendData(pat(9, k));
    endFrame(152); watch;
    chk("R4 low mid frame", busyCnt, 0);
    progFrame(80, 16, 9, 0); // build data only; count 0 starts nothing
    tick;
    startFrame; sendOp(8'h02); sendAddr(9'd80);
    for (int k = 0; k < 16; k++) sendData(pat(9, k));
    protectN = 0; endFrame(152); protectN = 1; watch;
    chk("R4 low at rise", busyCnt, 0);
    progFrame(80, 16, 9, 152);
    protectN = 0; watch; protectN = 1;
    chk("R4 cycle completes", weCnt, 1);
    chkLine("R4 line", gotLine, patLine(9));

    // R8 commands during busy are ignored
    setLock(0);
    startFrame; sendOp(8'h01); sendData(8'h06); endFrame(16);
    cmd(8'h04, 8);
    startFrame; sendOp(8'h01); sendData(8'h01); endFrame(16);
    watch;
    chk("R8 clear ignored", int'(progEnable), 1);
    chk("R8 lock from first", int'(lockCode), 6);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule